// File: doc/BRIEF.md
# Multi-Engine Interrupt Status Controller

This block collects interrupt causes from a set of copy engines and presents them to the host as one level-sensitive interrupt line. Each engine reports three kinds of cause as single-cycle pulses: copy complete, watermark and error. Every pulse is latched into that engine's status register whether or not the cause is enabled. The host turns causes on through two per-engine enable registers. The first enables copy complete and watermark. The second is a separate miscellaneous enable that holds the error enable.

A summary bitmap holds one bit per engine. A bit is set while that engine has at least one latched cause whose enable is on. The host line is the OR of the summary bits. The host services engines by scanning the bitmap from the lowest engine upward. It clears individual causes by writing a one-to-clear mask to the engine's status register. The highest-numbered engine is serviced by polling. Its status still latches, but it never contributes to the summary or to the interrupt line.

All registers are reached through a simple request port. Read data comes back one cycle after the request.

Top module: `eng_irq_agg`

## Requirements
- R1: After reset, every status and enable register reads zero, `summary_o` is zero and `irq_o` is low.
- R2: A pulse on `cc_evt_i[n]`, `wm_evt_i[n]` or `err_evt_i[n]` sets status bit 0, 1 or 2 of engine n on the next clock edge. This happens even when the matching enable is off, and no status bit is set without a pulse.
- R3: Writing a mask to an engine's status register clears exactly the status bits that are one in the mask. All other status bits keep their value.
- R4: If a cause pulse and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R5: `summary_o[n]` is one exactly when engine n has any enabled cause latched. The enables are: host-enable register bit 0 for copy complete, host-enable register bit 1 for watermark, and miscellaneous-enable register bit 0 for error.
- R6: `summary_o[NUM_ENG-1]` is always zero, whatever is written to that engine's enables or latched in its status.
- R7: `irq_o` is the OR of `summary_o`. It stays high with no further activity until a register write removes the last enabled pending cause.
- R8: The address decodes as follows. Bit 5 set selects the summary register, read-only, with writes ignored. Otherwise bits [4:2] select the engine and bits [1:0] select the register: 0 host enable, 1 miscellaneous enable, 2 status, 3 reserved (reads zero, writes ignored). Read data appears on `rdata_o`, with `rvalid_o` high, in the cycle after the read request.
- R9: Copy-complete and watermark status clear independently. Clearing one leaves the other latched, and the engine stays in the summary while the remaining cause is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cc_evt_i | input | NUM_ENG | Copy-complete cause pulses, one per engine |
| wm_evt_i | input | NUM_ENG | Watermark cause pulses, one per engine |
| err_evt_i | input | NUM_ENG | Error cause pulses, one per engine |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ENG_W+3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| summary_o | output | NUM_ENG | Per-engine pending-enabled bitmap |
| irq_o | output | 1 | Level-sensitive combined host interrupt |

## Verification
Two functions can land on the same status bit in the same cycle: an engine raising a cause, and the host clearing that cause with a one-to-clear write. The bench provokes this by driving an error pulse and a status write with the error bit in the mask on the same falling edge, so both are sampled by the same rising edge. It judges the result by reading the status register back through the register port, where the error bit must still be set, and by checking that the engine remains in the summary. A following clear with no pulse must then empty the register.

// File: rtl/eia_pkg.sv
package eia_pkg;
  localparam int unsigned NUM_CAUSE = 3;
  localparam int unsigned CAUSE_CC  = 0;
  localparam int unsigned CAUSE_WM  = 1;
  localparam int unsigned CAUSE_ERR = 2;

  typedef enum logic [1:0] {
    SEL_HOST_EN = 2'd0,
    SEL_MISC_EN = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_RSVD    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/eia_decode.sv
module eia_decode
  import eia_pkg::*;
#(
  parameter int unsigned NUM_ENG = 8,
  localparam int unsigned ENG_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  localparam int unsigned ADDR_W = ENG_W + 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_ENG-1:0] wr_host_en_o,
  output logic [NUM_ENG-1:0] wr_misc_en_o,
  output logic [NUM_ENG-1:0] wr_status_o,
  output logic [ENG_W-1:0]  rd_eng_o,
  output reg_sel_e          rd_sel_o,
  output logic              rd_summary_o
);
  logic             is_summary;
  logic [ENG_W-1:0] eng_idx;
  reg_sel_e         sel;
  logic             wr_eng;

  assign is_summary = addr_i[ADDR_W-1];
  assign eng_idx    = addr_i[ADDR_W-2:2];
  assign sel        = reg_sel_e'(addr_i[1:0]);
  assign wr_eng     = req_i && we_i && !is_summary;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_strobe
    logic hit;
    assign hit             = wr_eng && (eng_idx == ENG_W'(g));
    assign wr_host_en_o[g] = hit && (sel == SEL_HOST_EN);
    assign wr_misc_en_o[g] = hit && (sel == SEL_MISC_EN);
    assign wr_status_o[g]  = hit && (sel == SEL_STATUS);
  end

  assign rd_eng_o     = eng_idx;
  assign rd_sel_o     = sel;
  assign rd_summary_o = is_summary;
endmodule

// File: rtl/eia_slot.sv
module eia_slot
  import eia_pkg::*;
#(
  parameter bit POLLED = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic                 wr_host_en_i,
  input  logic                 wr_misc_en_i,
  input  logic                 wr_status_i,
  input  logic [NUM_CAUSE-1:0] wbits_i,
  output logic [NUM_CAUSE-1:0] status_o,
  output logic [1:0]           host_en_o,
  output logic                 misc_en_o,
  output logic                 pending_o
);
  logic [NUM_CAUSE-1:0] status_q, status_d, clr_mask;
  logic [1:0]           host_en_q;
  logic                 misc_en_q;

  assign clr_mask = wr_status_i ? wbits_i : '0;
  // set has priority over clear
  assign status_d = (status_q & ~clr_mask) | cause_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      host_en_q <= '0;
      misc_en_q <= 1'b0;
    end else begin
      status_q <= status_d;
      if (wr_host_en_i) host_en_q <= wbits_i[1:0];
      if (wr_misc_en_i) misc_en_q <= wbits_i[0];
    end
  end

  if (POLLED) begin : g_polled
    assign pending_o = 1'b0;
  end else begin : g_irq
    logic [NUM_CAUSE-1:0] en_vec;
    always_comb begin
      en_vec            = '0;
      en_vec[CAUSE_CC]  = host_en_q[0];
      en_vec[CAUSE_WM]  = host_en_q[1];
      en_vec[CAUSE_ERR] = misc_en_q;
    end
    assign pending_o = |(status_q & en_vec);
  end

  assign status_o  = status_q;
  assign host_en_o = host_en_q;
  assign misc_en_o = misc_en_q;

  // R2 and R4: a pulse always lands, even against a clear
  assert_cause_latched_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cause_i) |=> ((status_q & $past(cause_i)) == $past(cause_i)));

  assert_no_spurious_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|cause_i) |=> ((status_q & ~$past(status_q)) == '0));

  assert_clear_hits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status_i && !(|cause_i)) |=> ((status_q & $past(wbits_i)) == '0));
endmodule

// File: rtl/eia_summary.sv
module eia_summary #(
  parameter int unsigned NUM_ENG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENG-1:0] pending_i,
  output logic [NUM_ENG-1:0] summary_o,
  output logic               irq_o
);
  assign summary_o = pending_i;
  assign irq_o     = |pending_i;

  assert_last_engine_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !summary_o[NUM_ENG-1]);
endmodule

// File: rtl/eng_irq_agg.sv
module eng_irq_agg
  import eia_pkg::*;
#(
  parameter int unsigned NUM_ENG = 8,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned ENG_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
  localparam int unsigned ADDR_W = ENG_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENG-1:0] cc_evt_i,
  input  logic [NUM_ENG-1:0] wm_evt_i,
  input  logic [NUM_ENG-1:0] err_evt_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic [NUM_ENG-1:0] summary_o,
  output logic               irq_o
);
  logic [NUM_ENG-1:0] wr_host_en, wr_misc_en, wr_status, pending;
  logic [ENG_W-1:0]   rd_eng;
  reg_sel_e           rd_sel;
  logic               rd_summary;

  logic [NUM_CAUSE-1:0] status_a  [NUM_ENG];
  logic [1:0]           host_en_a [NUM_ENG];
  logic                 misc_en_a [NUM_ENG];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_CAUSE];

  eia_decode #(.NUM_ENG(NUM_ENG)) u_decode (
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wr_host_en_o (wr_host_en),
    .wr_misc_en_o (wr_misc_en),
    .wr_status_o  (wr_status),
    .rd_eng_o     (rd_eng),
    .rd_sel_o     (rd_sel),
    .rd_summary_o (rd_summary)
  );

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    logic [NUM_CAUSE-1:0] cause;
    always_comb begin
      cause            = '0;
      cause[CAUSE_CC]  = cc_evt_i[g];
      cause[CAUSE_WM]  = wm_evt_i[g];
      cause[CAUSE_ERR] = err_evt_i[g];
    end

    eia_slot #(.POLLED(g == NUM_ENG - 1)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cause_i      (cause),
      .wr_host_en_i (wr_host_en[g]),
      .wr_misc_en_i (wr_misc_en[g]),
      .wr_status_i  (wr_status[g]),
      .wbits_i      (wdata_i[NUM_CAUSE-1:0]),
      .status_o     (status_a[g]),
      .host_en_o    (host_en_a[g]),
      .misc_en_o    (misc_en_a[g]),
      .pending_o    (pending[g])
    );
  end

  eia_summary #(.NUM_ENG(NUM_ENG)) u_summary (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .summary_o (summary_o),
    .irq_o     (irq_o)
  );

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (rd_summary) begin
      rd_word[NUM_ENG-1:0] = summary_o;
    end else if (int'(rd_eng) < NUM_ENG) begin
      unique case (rd_sel)
        SEL_HOST_EN: rd_word[1:0]           = host_en_a[rd_eng];
        SEL_MISC_EN: rd_word[0]             = misc_en_a[rd_eng];
        SEL_STATUS:  rd_word[NUM_CAUSE-1:0] = status_a[rd_eng];
        default:     rd_word                = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= rd_word;
    end
  end

  // R7: the line only drops after a host write
  assert_irq_drop_needs_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i));

  assert_read_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
endmodule

// File: tb/eng_irq_agg_test.sv
module eng_irq_agg_test;
  localparam int NE = 8;
  localparam int DW = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] cc_evt = '0, wm_evt = '0, err_evt = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;
  logic [NE-1:0] summary;
  logic          irq;

  int checks = 0;
  int failures = 0;

  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  eng_irq_agg #(.NUM_ENG(NE), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cc_evt_i(cc_evt), .wm_evt_i(wm_evt), .err_evt_i(err_evt),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .summary_o(summary), .irq_o(irq)
  );

  function automatic logic [AW-1:0] ra(int eng, int sel);
    return {1'b0, 3'(eng), 2'(sel)};
  endfunction
  localparam logic [AW-1:0] SUM_ADDR = 6'b100000;

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8: unexpected read data 0x%0h expected none", rdata);
      end else begin
        chk(int'(rdata), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = DW'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] c, input logic [NE-1:0] w, input logic [NE-1:0] e);
    @(negedge clk);
    cc_evt = c; wm_evt = w; err_evt = e;
    @(negedge clk);
    cc_evt = '0; wm_evt = '0; err_evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(int'(irq), 0, "R1 irq after reset");
    chk(int'(summary), 0, "R1 summary after reset");
    do_read(ra(0, 2), 0, "R1 status eng0");
    do_read(ra(3, 0), 0, "R1 host enable eng3");
    do_read(SUM_ADDR, 0, "R1 summary register");

    // R2: masked cause still latches
    pulse(8'h04, 8'h00, 8'h00);
    chk(int'(summary), 0, "R5 masked cause not in summary");
    do_read(ra(2, 2), 1, "R2 masked cc latched eng2");

    // R5/R7: enabling raises summary and line
    do_write(ra(2, 0), 1);
    chk(int'(summary), 8'h04, "R5 cc enabled summary");
    chk(int'(irq), 1, "R7 irq raised");
    do_read(ra(2, 0), 1, "R8 host enable readback");
    repeat (5) @(negedge clk);
    chk(int'(irq), 1, "R7 irq level held");

    // R9: independent clear
    pulse(8'h00, 8'h04, 8'h00);
    do_write(ra(2, 0), 3);
    do_read(ra(2, 2), 3, "R2 cc and wm latched");
    do_write(ra(2, 2), 1);
    do_read(ra(2, 2), 2, "R9 wm kept after cc clear");
    chk(int'(summary), 8'h04, "R9 engine still pending");
    do_write(ra(2, 2), 2);
    do_read(ra(2, 2), 0, "R3 wm cleared");
    chk(int'(irq), 0, "R7 irq dropped after clear");

    // R5 error via misc enable, R3 partial mask
    do_write(ra(5, 1), 1);
    pulse(8'h00, 8'h00, 8'h20);
    chk(int'(summary), 8'h20, "R5 error enabled summary");
    do_write(ra(5, 2), 3);
    do_read(ra(5, 2), 4, "R3 unmasked err kept");
    chk(int'(summary), 8'h20, "R3 summary kept");

    // R4: set and clear in the same cycle
    @(negedge clk);
    err_evt = 8'h20; req = 1'b1; we = 1'b1; addr = ra(5, 2); wdata = 4;
    @(negedge clk);
    err_evt = '0; req = 1'b0; we = 1'b0;
    chk(int'(summary), 8'h20, "R4 set wins summary");
    do_read(ra(5, 2), 4, "R4 set wins status");
    do_write(ra(5, 2), 4);
    do_read(ra(5, 2), 0, "R3 err cleared alone");
    chk(int'(irq), 0, "R7 irq low after err clear");

    // R6: last engine polled
    do_write(ra(7, 0), 3);
    do_write(ra(7, 1), 1);
    pulse(8'h80, 8'h80, 8'h80);
    do_read(ra(7, 2), 7, "R6 last engine status latches");
    chk(int'(summary), 0, "R6 last engine not in summary");
    chk(int'(irq), 0, "R6 last engine no irq");

    // R8: ignored writes and reserved slot
    do_write(ra(0, 0), 1);
    do_write(ra(3, 0), 1);
    pulse(8'h09, 8'h00, 8'h00);
    chk(int'(summary), 8'h09, "R5 two engines pending");
    do_write(SUM_ADDR, 32'hFF);
    do_read(SUM_ADDR, 8'h09, "R8 summary write ignored");
    do_write(ra(0, 3), 7);
    do_read(ra(0, 3), 0, "R8 reserved reads zero");
    do_read(ra(0, 2), 1, "R8 reserved write left status");
    do_read(ra(0, 1), 0, "R8 misc enable eng0 untouched");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R8 all reads returned");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule